// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter Stage

This block is one stage of a synchronous binary counter that can step up or down on the rising clock edge. A direction pin picks the way it counts. An active-low enable gates counting. Two controls act at once, without waiting for a clock: a level-sensitive preset that forces the stage to a supplied value, and a master clear that overrides everything else.

An active-low terminal-count flag marks the last state before the count wraps in the current direction. The flag is gated by the stage's own enable. Wiring each stage's flag into the next stage's enable, with a common clock and direction, gives a wider up/down counter that ripples its enable from the least significant stage upward.

The preset value is shown on the outputs at once while preset is held. The value kept after preset falls is the one present at the last rising clock edge during preset, or at the rising edge of preset itself, whichever came later. The preset data must therefore stay steady from that moment until preset is released.

Top module: `updown_stage`

## Requirements
- R1: While `clr` is 1, `count` reads 0 at once, without a clock edge, whatever `preset`, `en_n`, `up` and `clk` are doing.
- R2: While `preset` is 1 and `clr` is 0, `count` equals `preset_val` without waiting for a clock edge. After `preset` falls, the stage keeps that value until a later count or clear.
- R3: With `clr`, `preset` and `en_n` all 0 and `up` = 1, each rising clock edge adds one to `count`, and 1111 wraps to 0000.
- R4: With `clr`, `preset` and `en_n` all 0 and `up` = 0, each rising clock edge subtracts one from `count`, and 0000 wraps to 1111.
- R5: With `clr` and `preset` at 0 and `en_n` = 1, `count` does not change across clock edges.
- R6: When `up` = 1, `tc_n` is 0 exactly when `count` is all ones and `en_n` is 0; otherwise it is 1.
- R7: When `up` = 0, `tc_n` is 0 exactly when `count` is all zeros and `en_n` is 0; otherwise it is 1.
- R8: `tc_n` follows changes on `up` and `en_n` combinationally, with no clock edge in between.
- R9: Two stages form an 8-bit up/down counter that wraps modulo 256 in both directions, including across the 0x0F/0x10 step. Both stages share `clk`, `clr` and `up`, and the upper stage's `en_n` is driven by the lower stage's `tc_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| clr | input | 1 | Asynchronous master clear, active high, highest priority |
| preset | input | 1 | Asynchronous level-sensitive preset, active high |
| preset_val | input | WIDTH | Value forced while preset is high |
| en_n | input | 1 | Count enable, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | WIDTH | Current counter value |
| tc_n | output | 1 | Terminal count, active low, gated by en_n |

## Verification
A behavioural model is compared with a single stage and with a two-stage cascade after every rising edge.

- Runs of upward and downward counting long enough to wrap show whether the increment and decrement paths, and their wrap points, are right.
- Enable-high stretches separate holding from counting.
- Preset and clear are pulsed between edges and sampled before any clock edge, which exposes a design that waits for the clock.
- Toggling direction and enable at a terminal state shows whether the flag is decoded per direction and gated.
- Several hundred cascaded cycles each way cover the 0x0F/0x10 carry and full wrap.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic [1:0] {
    UDC_HOLD = 2'd0,
    UDC_INC  = 2'd1,
    UDC_DEC  = 2'd2
  } udc_op_e;
endpackage

// File: rtl/udc_step.sv
module udc_step
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  udc_op_e          op,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // Natural modulo-2^WIDTH wrap in both directions
  always_comb begin
    unique case (op)
      UDC_INC: nxt = cur + ONE;
      UDC_DEC: nxt = cur - ONE;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/udc_term.sv
module udc_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             up,
  input  logic             en_n,
  output logic             tc_n
);
  logic at_top, at_bottom;

  assign at_top    = &cur;
  assign at_bottom = ~|cur;
  assign tc_n      = ~(~en_n & (up ? at_top : at_bottom));
endmodule

// File: rtl/updown_stage.sv
module updown_stage
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             preset,
  input  logic [WIDTH-1:0] preset_val,
  input  logic             en_n,
  input  logic             up,
  output logic [WIDTH-1:0] count,
  output logic             tc_n
);
  udc_op_e          op;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_nxt;

  always_comb begin
    if (en_n)    op = UDC_HOLD;
    else if (up) op = UDC_INC;
    else         op = UDC_DEC;
  end

  udc_step #(.WIDTH(WIDTH)) u_step (
    .op  (op),
    .cur (state_q),
    .nxt (state_nxt)
  );

  // Clear beats preset; preset is captured on its rise and on every edge it is held
  always_ff @(posedge clk or posedge clr or posedge preset) begin
    if (clr)         state_q <= '0;
    else if (preset) state_q <= preset_val;
    else             state_q <= state_nxt;
  end

  // Preset shows through at once while held
  assign count = (preset && !clr) ? preset_val : state_q;

  udc_term #(.WIDTH(WIDTH)) u_term (
    .cur  (count),
    .up   (up),
    .en_n (en_n),
    .tc_n (tc_n)
  );

  assert_count_up_R3: assert property (@(posedge clk) disable iff (clr || preset)
    (!en_n && up) |=> count == $past(count) + WIDTH'(1));

  assert_count_down_R4: assert property (@(posedge clk) disable iff (clr || preset)
    (!en_n && !up) |=> count == $past(count) - WIDTH'(1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (clr || preset)
    en_n |=> $stable(count));

  assert_tc_top_R6: assert property (@(posedge clk) disable iff (clr)
    (up && !en_n && (&count)) |-> !tc_n);

  assert_tc_bottom_R7: assert property (@(posedge clk) disable iff (clr)
    (!up && !en_n && count == '0) |-> !tc_n);

  assert_tc_gated_R6: assert property (@(posedge clk) disable iff (clr)
    en_n |-> tc_n);
endmodule

// File: tb/tb_updown_stage.sv
module tb_updown_stage;
  localparam int PERIOD = 10;

  logic       clk = 0;
  logic       clr, preset, en_n, up;
  logic [3:0] preset_val;
  logic [3:0] count;
  logic       tc_n;

  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_tc_n, hi_tc_n;

  int n_chk = 0, n_bad = 0;
  int m_one;   // single-stage model value
  int m_cas;   // cascade model value
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  updown_stage #(.WIDTH(4)) dut (
    .clk(clk), .clr(clr), .preset(preset), .preset_val(preset_val),
    .en_n(en_n), .up(up), .count(count), .tc_n(tc_n)
  );

  updown_stage #(.WIDTH(4)) cas_lo (
    .clk(clk), .clr(clr), .preset(1'b0), .preset_val(4'h0),
    .en_n(en_n), .up(up), .count(lo_cnt), .tc_n(lo_tc_n)
  );

  updown_stage #(.WIDTH(4)) cas_hi (
    .clk(clk), .clr(clr), .preset(1'b0), .preset_val(4'h0),
    .en_n(lo_tc_n), .up(up), .count(hi_cnt), .tc_n(hi_tc_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  function automatic int exp_one();
    if (clr) return 0;
    if (preset) return int'(preset_val);
    return m_one;
  endfunction

  function automatic int exp_tc(input int v, input int top);
    if (en_n) return 1;
    if (up) return (v == top) ? 0 : 1;
    return (v == 0) ? 0 : 1;
  endfunction

  // Model update at each edge, comparison a quarter period later
  always @(posedge clk) begin
    if (clr)         m_one = 0;
    else if (preset) m_one = int'(preset_val);
    else if (!en_n)  m_one = up ? (m_one + 1) % 16 : (m_one + 15) % 16;
    if (clr)         m_cas = 0;
    else if (!en_n)  m_cas = up ? (m_cas + 1) % 256 : (m_cas + 255) % 256;
    #(PERIOD/4);
    if (!done) begin
      chk(clr ? "R1" : preset ? "R2" : en_n ? "R5" : up ? "R3" : "R4",
          int'(count), exp_one());
      chk(up ? "R6" : "R7", int'(tc_n), exp_tc(exp_one(), 15));
      chk("R9", int'({hi_cnt, lo_cnt}), m_cas);
      chk("R9", int'(hi_tc_n), exp_tc(m_cas, 255));
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_one = 0; m_cas = 0;
    clr = 1; preset = 0; preset_val = 4'h0; en_n = 1; up = 1;
    #1;
    chk("R1", int'(count), 0);
    cycles(3);
    clr = 0;
    cycles(1);
    // R2: preset shows before any edge
    preset = 1; preset_val = 4'hD;
    #1 chk("R2", int'(count), 13);
    cycles(2);
    preset_val = 4'h3;
    #1 chk("R2", int'(count), 3);
    cycles(1);
    preset = 0;
    #1 chk("R2", int'(count), 3);
    // R3 through wrap
    en_n = 0; up = 1;
    cycles(20);
    // R5 hold
    en_n = 1;
    cycles(4);
    // R4 through wrap
    en_n = 0; up = 0;
    cycles(20);
    // R8: flag reacts to direction and enable without an edge
    en_n = 1; preset = 1; preset_val = 4'hF;
    cycles(1);
    preset = 0;
    cycles(1);
    en_n = 0; up = 1;
    #1 chk("R8", int'(tc_n), 0);
    up = 0;
    #1 chk("R8", int'(tc_n), 1);
    up = 1; en_n = 1;
    #1 chk("R8", int'(tc_n), 1);
    cycles(1);
    // R1: clear overrides a held preset mid-cycle
    preset = 1; preset_val = 4'h7;
    #1 chk("R2", int'(count), 7);
    clr = 1;
    #1 chk("R1", int'(count), 0);
    cycles(1);
    preset = 0;
    cycles(1);
    clr = 0;
    // R9 cascade: full wrap up then down
    en_n = 0; up = 1;
    cycles(300);
    up = 0;
    cycles(300);
    en_n = 1;
    cycles(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule